// File: doc/BRIEF.md
# Isochronous Microframe Transaction Error Checker

This block watches one high-bandwidth isochronous IN endpoint across each microframe. It counts the banks that software or DMA validates, the IN tokens that were answered with one of those banks, and the banks that actually went out on the bus. When an IN token finds no validated bank waiting, the block asks for a zero-length packet and raises a no-data error at once. At each microframe-end pulse it compares the counts with each other and with the programmed number of transactions per microframe (1 to 3). From that comparison it raises a flush error, a transaction-count error, or both. It also issues a one-cycle flush request that carries the number of validated banks that were never requested.

The three error flags are sticky, stay set until a write-one-to-clear strobe removes them, and can be set in any combination. The packet data path and token decoding sit outside this block. It sees only single-cycle event pulses.

Top module: `iso_uframe_chk`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `err_flags`, `send_zlp`, `flush_req` and `flush_cnt` are all zero.
- R2: A microframe with no IN token ends with no flag set and no flush request, even when banks were validated in it.
- R3: An IN token that finds no validated bank left unanswered in the current microframe raises `send_zlp` for exactly the cycle after the token. In that same cycle it sets the no-data flag, `err_flags[0]`. A validation that arrives in the same cycle as the token is too late for it.
- R4: An IN token that finds an unanswered validated bank consumes that bank and produces no `send_zlp` and no no-data flag.
- R5: At a microframe end where at least one bank was sent and more banks were validated than tokens answered, the flush flag `err_flags[1]` is set. In the cycle after the end, `flush_req` pulses for one cycle with `flush_cnt` equal to validated minus answered.
- R6: At a microframe end where at least one bank was sent and fewer banks were validated than `nb_trans`, the transaction-count flag `err_flags[2]` is set in the cycle after the end.
- R7: At a microframe end where no bank-sent pulse occurred, neither the flush flag nor the count flag is set and no flush request is issued.
- R8: Each flag stays set until its bit of `err_clr` is pulsed high (bit 0 no-data, bit 1 flush, bit 2 count). If a set and a clear reach the same flag in the same cycle, the set wins.
- R9: The validated, answered and sent counts saturate at 3 and restart at every microframe end. An event that coincides with the end pulse counts toward the new microframe.
- R10: A microframe with a late validation for the second token and no third bank, under `nb_trans` = 3, sets all three flags together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_in | input | 1 | One-cycle pulse: IN token received |
| bank_valid | input | 1 | One-cycle pulse: a bank was validated for sending |
| bank_sent | input | 1 | One-cycle pulse: a bank was transmitted |
| uframe_end | input | 1 | One-cycle pulse: end of the current microframe |
| nb_trans | input | 2 | Programmed transactions per microframe (1 to 3) |
| err_clr | input | 3 | Write-one-to-clear strobe for the error flags |
| err_flags | output | 3 | Sticky flags: bit 0 no-data, bit 1 flush, bit 2 count |
| send_zlp | output | 1 | One-cycle request to answer the last token with a zero-length packet |
| flush_req | output | 1 | One-cycle request to discard unrequested validated banks |
| flush_cnt | output | 2 | Number of banks to discard, valid while `flush_req` is high |

## Verification
Every result sits exactly one register behind the stimulus that causes it. `send_zlp` and the no-data flag follow the token by one cycle. The flush and count flags, together with `flush_req` and `flush_cnt`, follow the microframe-end pulse by one cycle, and a clear strobe takes effect on the flags one cycle later. The bench drives each pulse for one cycle from a falling edge and samples at the next falling edge, which is the first point where the registered result is visible. It samples once more a cycle later wherever a signal must be shown to be a single-cycle pulse.

// File: rtl/iso_uframe_pkg.sv
package iso_uframe_pkg;
  localparam int FLG_W      = 3;
  localparam int FLG_NODATA = 0;
  localparam int FLG_FLUSH  = 1;
  localparam int FLG_COUNT  = 2;
endpackage

// File: rtl/iso_sat_cnt.sv
module iso_sat_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};

  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en  = restart | (inc & (cnt != MAX_V));
    cnt_nxt = cnt;
    if (restart)
      cnt_nxt = inc ? {{(W-1){1'b0}}, 1'b1} : '0;
    else if (inc && cnt != MAX_V)
      cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt_en)
      cnt <= cnt_nxt;
  end

  // R9: a full count never wraps while the microframe continues
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == MAX_V && !$past(restart)) |-> cnt == MAX_V);
endmodule

// File: rtl/iso_frame_eval.sv
module iso_frame_eval #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         uframe_end,
  input  logic [W-1:0] nb_trans,
  input  logic [W-1:0] val_cnt,
  input  logic [W-1:0] ans_cnt,
  input  logic [W-1:0] sent_cnt,
  output logic         flush_set,
  output logic         count_set,
  output logic         flush_req,
  output logic [W-1:0] flush_cnt
);
  logic         sent_any;
  logic         flush_req_nxt;
  logic [W-1:0] flush_cnt_nxt;

  always_comb begin
    sent_any      = (sent_cnt != '0);
    flush_set     = uframe_end & sent_any & (val_cnt > ans_cnt);
    count_set     = uframe_end & sent_any & (val_cnt < nb_trans);
    flush_req_nxt = flush_set;
    flush_cnt_nxt = flush_set ? (val_cnt - ans_cnt) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_req <= 1'b0;
      flush_cnt <= '0;
    end else begin
      flush_req <= flush_req_nxt;
      flush_cnt <= flush_cnt_nxt;
    end
  end

  // R5: a flush request only follows a microframe end
  p_flush_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(uframe_end));
  // R5: a flush request always names at least one bank
  p_flush_cnt_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> flush_cnt != '0);
endmodule

// File: rtl/iso_err_flags.sv
module iso_err_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_nxt;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb flags_nxt[i] = set[i] | (flags[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else
        flags[i] <= flags_nxt[i];
    end

    // R8: a flag holds unless its clear bit was pulsed
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flags[i]) && !$past(clr[i])) |-> flags[i]);
    // R8: a set beats a simultaneous clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set[i]) |-> flags[i]);
  end
endmodule

// File: rtl/iso_uframe_chk.sv
module iso_uframe_chk
  import iso_uframe_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_in,
  input  logic             bank_valid,
  input  logic             bank_sent,
  input  logic             uframe_end,
  input  logic [CNT_W-1:0] nb_trans,
  input  logic [FLG_W-1:0] err_clr,
  output logic [FLG_W-1:0] err_flags,
  output logic             send_zlp,
  output logic             flush_req,
  output logic [CNT_W-1:0] flush_cnt
);
  logic [CNT_W-1:0] val_cnt;
  logic [CNT_W-1:0] ans_cnt;
  logic [CNT_W-1:0] sent_cnt;
  logic             bank_waiting;
  logic             ans_inc;
  logic             zlp_nxt;
  logic             flush_set;
  logic             count_set;
  logic [FLG_W-1:0] flag_set;

  // a bank validated in this very cycle is not yet visible to a token
  always_comb begin
    bank_waiting = !uframe_end && (val_cnt > ans_cnt);
    ans_inc      = tok_in & bank_waiting;
    zlp_nxt      = tok_in & ~bank_waiting;
  end

  iso_sat_cnt #(.W(CNT_W)) u_val_cnt (
    .clk(clk), .rst_n(rst_n), .inc(bank_valid), .restart(uframe_end), .cnt(val_cnt));

  iso_sat_cnt #(.W(CNT_W)) u_ans_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ans_inc), .restart(uframe_end), .cnt(ans_cnt));

  iso_sat_cnt #(.W(CNT_W)) u_sent_cnt (
    .clk(clk), .rst_n(rst_n), .inc(bank_sent), .restart(uframe_end), .cnt(sent_cnt));

  iso_frame_eval #(.W(CNT_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .uframe_end(uframe_end), .nb_trans(nb_trans),
    .val_cnt(val_cnt), .ans_cnt(ans_cnt), .sent_cnt(sent_cnt),
    .flush_set(flush_set), .count_set(count_set),
    .flush_req(flush_req), .flush_cnt(flush_cnt));

  always_comb begin
    flag_set             = '0;
    flag_set[FLG_NODATA] = zlp_nxt;
    flag_set[FLG_FLUSH]  = flush_set;
    flag_set[FLG_COUNT]  = count_set;
  end

  iso_err_flags #(.N(FLG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(err_clr), .flags(err_flags));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      send_zlp <= 1'b0;
    else
      send_zlp <= zlp_nxt;
  end

  // R3: a zero-length packet is only requested right after a token
  p_zlp_after_tok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_zlp |-> $past(tok_in));
  // R3: each zero-length request comes with the no-data flag
  p_zlp_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_zlp |-> err_flags[FLG_NODATA]);
  // R4: answered tokens never outrun validated banks
  p_ans_le_val_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ans_cnt <= val_cnt);
endmodule

// File: tb/iso_uframe_chk_tb.sv
`timescale 1ns/1ps
module iso_uframe_chk_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tok_in, bank_valid, bank_sent, uframe_end;
  logic [1:0] nb_trans;
  logic [2:0] err_clr;
  logic [2:0] err_flags;
  logic       send_zlp, flush_req;
  logic [1:0] flush_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  iso_uframe_chk u_dut (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .bank_valid(bank_valid),
    .bank_sent(bank_sent), .uframe_end(uframe_end), .nb_trans(nb_trans),
    .err_clr(err_clr), .err_flags(err_flags), .send_zlp(send_zlp),
    .flush_req(flush_req), .flush_cnt(flush_cnt));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle of pulses starting at a falling edge; returns at next falling edge
  task automatic step(input logic t, input logic v, input logic s,
                      input logic e, input logic [2:0] c);
    tok_in = t; bank_valid = v; bank_sent = s; uframe_end = e; err_clr = c;
    @(negedge clk);
    tok_in = 0; bank_valid = 0; bank_sent = 0; uframe_end = 0; err_clr = 0;
  endtask

  task automatic tidy();
    step(0, 0, 0, 1, 3'b111);
    step(0, 0, 0, 0, 3'b111);
  endtask

  task automatic t_reset();
    check("R1 flags", err_flags, 0);
    check("R1 zlp", send_zlp, 0);
    check("R1 flush_req", flush_req, 0);
    check("R1 flush_cnt", flush_cnt, 0);
  endtask

  task automatic t_no_token();
    nb_trans = 3;
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    check("R2 flags", err_flags, 0);
    check("R2 flush_req", flush_req, 0);
    tidy();
  endtask

  task automatic t_clean();
    nb_trans = 2;
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    check("R4 zlp1", send_zlp, 0);
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    check("R4 zlp2", send_zlp, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    check("R4 R6 flags", err_flags, 0);
    check("R5 no flush", flush_req, 0);
    tidy();
  endtask

  task automatic t_nodata();
    nb_trans = 1;
    step(1, 0, 0, 0, 0);
    check("R3 zlp", send_zlp, 1);
    check("R3 flag", err_flags, 3'b001);
    step(0, 0, 0, 0, 0);
    check("R3 zlp pulse", send_zlp, 0);
    step(0, 0, 0, 1, 0);
    check("R7 only nodata", err_flags, 3'b001);
    step(0, 0, 0, 0, 3'b111);
    check("R8 cleared", err_flags, 0);
    step(1, 1, 0, 0, 0);
    check("R3 same-cycle valid", send_zlp, 1);
    tidy();
  endtask

  task automatic t_flush_count();
    nb_trans = 3;
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    check("R5 R6 flags", err_flags, 3'b110);
    check("R5 flush_req", flush_req, 1);
    check("R5 flush_cnt", flush_cnt, 1);
    step(0, 0, 0, 0, 0);
    check("R5 flush pulse", flush_req, 0);
    step(0, 0, 0, 0, 3'b010);
    check("R8 clear one", err_flags, 3'b100);
    tidy();
  endtask

  task automatic t_all_three();
    nb_trans = 3;
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    check("R10 late zlp", send_zlp, 1);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    check("R10 flags", err_flags, 3'b111);
    check("R10 flush_cnt", flush_cnt, 1);
    tidy();
  endtask

  task automatic t_unsent();
    nb_trans = 3;
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    check("R7 flags", err_flags, 0);
    check("R7 flush_req", flush_req, 0);
    tidy();
  endtask

  task automatic t_set_wins();
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 3'b001);
    check("R8 set wins", err_flags, 3'b001);
    tidy();
  endtask

  task automatic t_saturate();
    nb_trans = 1;
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    check("R9 sat flush_cnt", flush_cnt, 2);
    check("R9 sat flags", err_flags, 3'b010);
    tidy();
  endtask

  task automatic t_end_carry();
    nb_trans = 1;
    step(0, 1, 0, 1, 0);
    step(1, 0, 0, 0, 0);
    check("R9 carry zlp", send_zlp, 0);
    check("R9 carry flag", err_flags, 0);
    tidy();
  endtask

  initial begin
    rst_n = 0; tok_in = 0; bank_valid = 0; bank_sent = 0; uframe_end = 0;
    err_clr = 0; nb_trans = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_token();
    t_clean();
    t_nodata();
    t_flush_count();
    t_all_three();
    t_unsent();
    t_set_wins();
    t_saturate();
    t_end_carry();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule